// File: doc/BRIEF.md
# PHY Control-Register Handshake Master

This block runs single transactions against the internal configuration port of a serial PHY. A host issues one operation at a time: capture a register address, write a data word, or read a data word. It gives a start pulse together with an operation code and a 16-bit word. The block then drives the PHY's strobes one at a time. For every strobe it waits for the acknowledge line to rise and then fall again, polling with a programmable number of idle cycles between checks and giving up after a bounded number of checks.

A write captures the data word first and only then pulses the write strobe. There is one exception. When the last captured address is the PHY's clock/reset register and bit 0 of the data is set, the write puts the PHY into reset and the PHY cannot answer. The block then raises the write strobe for a single cycle and reports success without waiting for acknowledge. At the end of each transaction the block gives a one-cycle done pulse, an error flag that stays set after a timeout, and the captured read data.

Top module: `phy_cr_master`

## Requirements
- R1: With `op_i` = 2'b00, the word is placed on `phy_din_o` and `phy_cap_addr_o` is raised. It is lowered once acknowledge is seen high, and the transaction succeeds once acknowledge is then seen low.
- R2: With `op_i` = 2'b01, a full `phy_cap_data_o` handshake presents the data word first. Only after that handshake completes does `phy_write_o` get its own full high/low handshake.
- R3: With `op_i` = 2'b10 or 2'b11, `phy_read_o` is raised and `phy_dout_i` is latched into `rdata_o` on the check that sees acknowledge high. The strobe then drops and the block waits for acknowledge low. A read that times out leaves `rdata_o` unchanged.
- R4: Each wait for an acknowledge level makes at most MAX_CHECKS (10) checks. After the last failed check, the active strobe drops, `err_o` is set, done pulses and the block returns to idle.
- R5: Before every check there are `gap_i` idle cycles. A strobe that is never acknowledged therefore stays high for exactly MAX_CHECKS*(`gap_i`+1) cycles.
- R6: Some writes skip the acknowledge wait. This applies when the last successfully captured address equals RST_ADDR (16'h7F3F) and bit 0 of the data is set. After the data capture, `phy_write_o` is high for one cycle and the transaction succeeds without any acknowledge wait. Any other write waits for acknowledge normally.
- R7: At most one of the four PHY strobes is high in any cycle.
- R8: `phy_din_o` is set up at least one cycle before a capture strobe rises. It does not change while that strobe is high.
- R9: `err_o` keeps its value until the next accepted start, which clears it.
- R10: A start pulse that arrives while a transaction is in progress is ignored.
- R11: After reset all strobes, `done_o`, `err_o` and `rdata_o` are zero.
- R12: `done_o` is high for exactly one cycle at the end of every transaction, whether it succeeds or times out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| op_i | input | 2 | 00 address capture, 01 write, 10/11 read |
| wdata_i | input | 16 | Address or write data |
| gap_i | input | GAP_W | Idle cycles inserted before each acknowledge check |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| err_o | output | 1 | Timeout flag, held until next start |
| rdata_o | output | 16 | Last successfully read word |
| phy_din_o | output | 16 | Data/address bus to the PHY |
| phy_cap_addr_o | output | 1 | Address capture strobe |
| phy_cap_data_o | output | 1 | Data capture strobe |
| phy_write_o | output | 1 | Write strobe |
| phy_read_o | output | 1 | Read strobe |
| phy_ack_i | input | 1 | Acknowledge from the PHY |
| phy_dout_i | input | 16 | Read data from the PHY |

## Verification
The hardest case to reach is the reset-write shortcut. It requires a prior successful capture of the clock/reset address, and then a write whose data has bit 0 set, issued to a PHY model that never acknowledges the write strobe. The stimulus table reaches it with a sequence of capture, shortcut write and then ordinary timed-out writes, using a responder that can ignore individual strobes. The same responder ignores a single strobe so that the exact strobe-high duration for two poll gaps can be measured.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;

  typedef enum logic [1:0] {
    OP_ADDR  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_READB = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HI,
    ST_LO,
    ST_RSTW
  } st_e;

  // stage value equals the index of its strobe in the strobe vector
  typedef enum logic [1:0] {
    SG_ADDR = 2'd0,
    SG_DATA = 2'd1,
    SG_WR   = 2'd2,
    SG_RD   = 2'd3
  } stage_e;

  localparam int NSTB = 4;

  function automatic logic [NSTB-1:0] stage_mask(stage_e s);
    return NSTB'(1) << s;
  endfunction

endpackage

// File: rtl/phy_cr_poll.sv
module phy_cr_poll #(
  parameter int GAP_W      = 8,
  parameter int MAX_CHECKS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             waiting_i,
  input  logic [GAP_W-1:0] gap_i,
  output logic             tick_o,
  output logic             final_o
);

  localparam int CNT_W = $clog2(MAX_CHECKS + 1);

  logic [GAP_W-1:0] gap_q, gap_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd;

  assign tick_o  = (gap_q == '0);
  assign final_o = (cnt_q == CNT_W'(MAX_CHECKS - 1));

  always_comb begin
    gap_d = gap_q;
    cnt_d = cnt_q;
    upd   = 1'b0;
    if (restart_i) begin
      gap_d = gap_i;
      cnt_d = '0;
      upd   = 1'b1;
    end else if (waiting_i) begin
      upd = 1'b1;
      if (tick_o) begin
        gap_d = gap_i;
        cnt_d = cnt_q + CNT_W'(1);
      end else begin
        gap_d = gap_q - GAP_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
      cnt_q <= '0;
    end else if (upd) begin
      gap_q <= gap_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/phy_cr_datapath.sv
module phy_cr_datapath #(
  parameter int          DW       = 16,
  parameter logic [15:0] RST_ADDR = 16'h7F3F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          keep_addr_i,
  input  logic          rd_latch_i,
  input  logic [DW-1:0] dout_i,
  output logic [DW-1:0] din_o,
  output logic [DW-1:0] rdata_o,
  output logic          rst_hit_o
);

  logic [DW-1:0] din_q, addr_q, rdata_q;

  assign din_o     = din_q;
  assign rdata_o   = rdata_q;
  assign rst_hit_o = (addr_q == DW'(RST_ADDR)) && din_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q <= '0;
    end else if (load_i) begin
      din_q <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (keep_addr_i) begin
      addr_q <= din_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_latch_i) begin
      rdata_q <= dout_i;
    end
  end

endmodule

// File: rtl/phy_cr_seq.sv
module phy_cr_seq
  import phy_cr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [1:0]      op_i,
  input  logic            ack_i,
  input  logic            tick_i,
  input  logic            final_i,
  input  logic            rst_hit_i,
  output logic [NSTB-1:0] strobe_o,
  output logic            load_o,
  output logic            keep_addr_o,
  output logic            rd_latch_o,
  output logic            restart_o,
  output logic            waiting_o,
  output logic            done_o,
  output logic            err_o
);

  st_e             state_q, state_d;
  stage_e          stage_q, stage_d;
  logic [NSTB-1:0] stb_q, stb_d;
  logic            done_q, done_d;
  logic            err_q, err_d;
  op_e             op;

  assign op        = op_e'(op_i);
  assign strobe_o  = stb_q;
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign waiting_o = (state_q == ST_HI) || (state_q == ST_LO);

  always_comb begin
    state_d     = state_q;
    stage_d     = stage_q;
    stb_d       = stb_q;
    done_d      = 1'b0;
    err_d       = err_q;
    load_o      = 1'b0;
    keep_addr_o = 1'b0;
    rd_latch_o  = 1'b0;
    restart_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          err_d   = 1'b0;
          state_d = ST_SETUP;
          unique case (op)
            OP_ADDR:  stage_d = SG_ADDR;
            OP_WRITE: stage_d = SG_DATA;
            default:  stage_d = SG_RD;
          endcase
        end
      end
      ST_SETUP: begin
        stb_d     = stage_mask(stage_q);
        state_d   = ST_HI;
        restart_o = 1'b1;
      end
      ST_HI: begin
        if (tick_i) begin
          if (ack_i) begin
            rd_latch_o = (stage_q == SG_RD);
            stb_d      = '0;
            state_d    = ST_LO;
            restart_o  = 1'b1;
          end else if (final_i) begin
            stb_d   = '0;
            err_d   = 1'b1;
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_LO: begin
        if (tick_i) begin
          if (!ack_i) begin
            unique case (stage_q)
              SG_ADDR: begin
                keep_addr_o = 1'b1;
                done_d      = 1'b1;
                state_d     = ST_IDLE;
              end
              SG_DATA: begin
                stb_d   = stage_mask(SG_WR);
                stage_d = SG_WR;
                if (rst_hit_i) begin
                  state_d = ST_RSTW;
                end else begin
                  state_d   = ST_HI;
                  restart_o = 1'b1;
                end
              end
              default: begin
                done_d  = 1'b1;
                state_d = ST_IDLE;
              end
            endcase
          end else if (final_i) begin
            err_d   = 1'b1;
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_RSTW: begin
        stb_d   = '0;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: begin
        stb_d   = '0;
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      stage_q <= SG_ADDR;
      stb_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      stage_q <= stage_d;
      stb_q   <= stb_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

endmodule

// File: rtl/phy_cr_master.sv
module phy_cr_master
  import phy_cr_pkg::*;
#(
  parameter int          DW         = 16,
  parameter int          GAP_W      = 8,
  parameter int          MAX_CHECKS = 10,
  parameter logic [15:0] RST_ADDR   = 16'h7F3F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [GAP_W-1:0] gap_i,
  output logic             done_o,
  output logic             err_o,
  output logic [DW-1:0]    rdata_o,
  output logic [DW-1:0]    phy_din_o,
  output logic             phy_cap_addr_o,
  output logic             phy_cap_data_o,
  output logic             phy_write_o,
  output logic             phy_read_o,
  input  logic             phy_ack_i,
  input  logic [DW-1:0]    phy_dout_i
);

  logic [NSTB-1:0] strobe;
  logic load, keep_addr, rd_latch, restart, waiting;
  logic tick, last_chk, rst_hit;

  phy_cr_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .op_i       (op_i),
    .ack_i      (phy_ack_i),
    .tick_i     (tick),
    .final_i    (last_chk),
    .rst_hit_i  (rst_hit),
    .strobe_o   (strobe),
    .load_o     (load),
    .keep_addr_o(keep_addr),
    .rd_latch_o (rd_latch),
    .restart_o  (restart),
    .waiting_o  (waiting),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  phy_cr_poll #(
    .GAP_W     (GAP_W),
    .MAX_CHECKS(MAX_CHECKS)
  ) u_poll (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart_i(restart),
    .waiting_i(waiting),
    .gap_i    (gap_i),
    .tick_o   (tick),
    .final_o  (last_chk)
  );

  phy_cr_datapath #(
    .DW      (DW),
    .RST_ADDR(RST_ADDR)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .wdata_i    (wdata_i),
    .keep_addr_i(keep_addr),
    .rd_latch_i (rd_latch),
    .dout_i     (phy_dout_i),
    .din_o      (phy_din_o),
    .rdata_o    (rdata_o),
    .rst_hit_o  (rst_hit)
  );

  assign phy_cap_addr_o = strobe[SG_ADDR];
  assign phy_cap_data_o = strobe[SG_DATA];
  assign phy_write_o    = strobe[SG_WR];
  assign phy_read_o     = strobe[SG_RD];

endmodule

// File: rtl/phy_cr_master_chk.sv
module phy_cr_master_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          done_o,
  input logic          err_o,
  input logic [DW-1:0] phy_din_o,
  input logic          phy_cap_addr_o,
  input logic          phy_cap_data_o,
  input logic          phy_write_o,
  input logic          phy_read_o
);

  // R7
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({phy_cap_addr_o, phy_cap_data_o, phy_write_o, phy_read_o}));

  // R8
  din_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_cap_addr_o || phy_cap_data_o) |-> $stable(phy_din_o));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !start_i) |=> err_o);

  // R4
  timeout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> (done_o && !phy_cap_addr_o && !phy_cap_data_o
                      && !phy_write_o && !phy_read_o));

endmodule

bind phy_cr_master phy_cr_master_chk #(.DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .done_o        (done_o),
  .err_o         (err_o),
  .phy_din_o     (phy_din_o),
  .phy_cap_addr_o(phy_cap_addr_o),
  .phy_cap_data_o(phy_cap_data_o),
  .phy_write_o   (phy_write_o),
  .phy_read_o    (phy_read_o)
);

// File: tb/phy_cr_master_tb_top.sv
module phy_cr_master_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [15:0] wdata_i = '0;
  logic [7:0]  gap_i = '0;
  logic        done_o, err_o;
  logic [15:0] rdata_o, phy_din_o, phy_dout_i;
  logic        phy_cap_addr_o, phy_cap_data_o, phy_write_o, phy_read_o;
  logic        phy_ack_i;

  always #10 clk = ~clk;

  phy_cr_master dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .wdata_i(wdata_i), .gap_i(gap_i), .done_o(done_o), .err_o(err_o),
    .rdata_o(rdata_o), .phy_din_o(phy_din_o),
    .phy_cap_addr_o(phy_cap_addr_o), .phy_cap_data_o(phy_cap_data_o),
    .phy_write_o(phy_write_o), .phy_read_o(phy_read_o),
    .phy_ack_i(phy_ack_i), .phy_dout_i(phy_dout_i)
  );

  // ---------------- PHY responder ----------------
  int          r_delay = 0;
  logic [3:0]  r_deaf = 4'b0000;
  int          r_cnt;
  logic [3:0]  stb, stb_prev;
  logic [15:0] r_addr, r_data;
  int          r_wr_cnt;
  logic        want;

  assign stb        = {phy_read_o, phy_write_o, phy_cap_data_o, phy_cap_addr_o};
  assign want       = |(stb & ~r_deaf);
  assign phy_dout_i = r_addr ^ 16'h5A5A;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_ack_i <= 1'b0; r_cnt <= 0; stb_prev <= '0;
      r_addr <= '0; r_data <= '0; r_wr_cnt <= 0;
    end else begin
      stb_prev <= stb;
      if (stb[0] && !stb_prev[0]) r_addr <= phy_din_o;
      if (stb[1] && !stb_prev[1]) r_data <= phy_din_o;
      if (stb[2] && !stb_prev[2]) r_wr_cnt <= r_wr_cnt + 1;
      if (want != phy_ack_i) begin
        if (r_cnt >= r_delay) begin
          phy_ack_i <= want; r_cnt <= 0;
        end else r_cnt <= r_cnt + 1;
      end else r_cnt <= 0;
    end
  end

  // ---------------- monitors ----------------
  int          n_checks = 0, n_fail = 0;
  int          multi_cnt = 0, din_chg_cnt = 0, ca_high = 0, stb_cycles = 0;
  logic [15:0] din_prev = '0;
  int          cyc = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if ((32'(stb[0]) + 32'(stb[1]) + 32'(stb[2]) + 32'(stb[3])) > 1) multi_cnt <= multi_cnt + 1;
      if ((stb[0] || stb[1]) && phy_din_o != din_prev) din_chg_cnt <= din_chg_cnt + 1;
      if (stb[0]) ca_high <= ca_high + 1;
      if (stb != 4'b0000) stb_cycles <= stb_cycles + 1;
    end
    din_prev <= phy_din_o;
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h1, 16'h0);
      finish_run();
    end
  end

  task automatic run_txn(input logic [1:0] op, input logic [15:0] d, input int dly,
                         input logic [7:0] gap, input logic [3:0] deaf);
    bit seen;
    r_delay = dly; r_deaf = deaf;
    @(negedge clk);
    op_i = op; wdata_i = d; gap_i = gap; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 3000 && !seen; k++) begin
      if (done_o) seen = 1'b1;
      else @(negedge clk);
    end
    chk(seen, "R12 done seen", 16'(seen), 16'h1);
    @(negedge clk);
    chk(!done_o, "R12 done width", 16'(done_o), 16'h0);
  endtask

  // op, data, delay, gap, deaf mask {rd,wr,cd,ca}, exp err, exp rdata
  localparam logic [46:0] VEC [12] = '{
    {2'd0, 16'h1234, 4'd1, 4'd0, 4'b0000, 1'b0, 16'h0000},
    {2'd2, 16'h0000, 4'd2, 4'd1, 4'b0000, 1'b0, 16'h486E},
    {2'd1, 16'hBEEF, 4'd0, 4'd2, 4'b0000, 1'b0, 16'h0000},
    {2'd0, 16'h7F3F, 4'd3, 4'd0, 4'b0000, 1'b0, 16'h0000},
    {2'd1, 16'h0001, 4'd1, 4'd0, 4'b0100, 1'b0, 16'h0000},
    {2'd1, 16'h0002, 4'd1, 4'd0, 4'b0100, 1'b1, 16'h0000},
    {2'd2, 16'h0000, 4'd1, 4'd0, 4'b0000, 1'b0, 16'h2565},
    {2'd0, 16'h0100, 4'd1, 4'd1, 4'b0001, 1'b1, 16'h0000},
    {2'd2, 16'h0000, 4'd2, 4'd1, 4'b1000, 1'b1, 16'h2565},
    {2'd0, 16'h0042, 4'd0, 4'd0, 4'b0000, 1'b0, 16'h0000},
    {2'd1, 16'h0001, 4'd0, 4'd0, 4'b0100, 1'b1, 16'h0000},
    {2'd3, 16'h0000, 4'd0, 4'd3, 4'b0000, 1'b0, 16'h5A18}
  };

  initial begin
    int wr_before;
    string tag;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(stb == 4'b0000 && !done_o && !err_o, "R11 ctrl", {12'h0, stb}, 16'h0);
    chk(rdata_o == 16'h0, "R11 rdata", rdata_o, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 12; i++) begin
      logic [1:0]  v_op;
      logic [15:0] v_d, v_rd;
      logic [3:0]  v_deaf;
      logic        v_err;
      v_op = VEC[i][46:45]; v_d = VEC[i][44:29]; v_deaf = VEC[i][20:17];
      v_err = VEC[i][16]; v_rd = VEC[i][15:0];
      wr_before = r_wr_cnt;
      run_txn(v_op, v_d, int'(VEC[i][28:25]), {4'h0, VEC[i][24:21]}, v_deaf);
      if (v_op == 2'd1 && v_deaf == 4'b0100) tag = "R6";
      else if (v_err) tag = "R4";
      else if (v_op == 2'd0) tag = "R1";
      else if (v_op == 2'd1) tag = "R2";
      else tag = "R3";
      chk(err_o == v_err, tag, 16'(err_o), 16'(v_err));
      if (v_op[1]) chk(rdata_o == v_rd, "R3 rdata", rdata_o, v_rd);
      if (v_op == 2'd0 && !v_err) chk(r_addr == v_d, "R1 addr", r_addr, v_d);
      if (v_op == 2'd1) begin
        chk(r_data == v_d, "R2 data", r_data, v_d);
        chk(r_wr_cnt == wr_before + 1, "R2 write strobe", 16'(r_wr_cnt), 16'(wr_before + 1));
      end
    end

    // R5 / R4: strobe high duration on an unacknowledged strobe
    ca_high = 0;
    run_txn(2'd0, 16'h0011, 0, 8'd0, 4'b0001);
    chk(ca_high == 10, "R5 gap0 duration", 16'(ca_high), 16'd10);
    chk(err_o, "R4 timeout", 16'(err_o), 16'h1);
    ca_high = 0;
    run_txn(2'd0, 16'h0012, 0, 8'd3, 4'b0001);
    chk(ca_high == 40, "R5 gap3 duration", 16'(ca_high), 16'd40);

    // R9: error held, then cleared by next start
    repeat (20) @(negedge clk);
    chk(err_o, "R9 hold", 16'(err_o), 16'h1);
    r_deaf = 4'b0000; r_delay = 1;
    op_i = 2'd0; wdata_i = 16'h0077; gap_i = 8'd1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(!err_o, "R9 clear", 16'(err_o), 16'h0);
    repeat (200) @(negedge clk);

    // R10: start ignored while busy
    wr_before = r_wr_cnt;
    r_delay = 3; r_deaf = 4'b0000;
    op_i = 2'd0; wdata_i = 16'h0AAA; gap_i = 8'd2; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    op_i = 2'd1; wdata_i = 16'hFFFF; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 500 && !done_o; k++) @(negedge clk);
    chk(r_addr == 16'h0AAA, "R10 addr", r_addr, 16'h0AAA);
    chk(!err_o, "R10 err", 16'(err_o), 16'h0);
    stb_cycles = 0;
    repeat (40) @(negedge clk);
    chk(stb_cycles == 0, "R10 no second txn", 16'(stb_cycles), 16'h0);
    chk(r_wr_cnt == wr_before, "R10 no write", 16'(r_wr_cnt), 16'(wr_before));

    chk(multi_cnt == 0, "R7 one strobe", 16'(multi_cnt), 16'h0);
    chk(din_chg_cnt == 0, "R8 din stable", 16'(din_chg_cnt), 16'h0);
    finish_run();
  end

endmodule